// File: doc/BRIEF.md
# Programmable Loop Address Generator

This block is a small programmable address sequencer placed in front of one embedded data memory of up to 1K words. A host first loads a short program into a local instruction store. Each store entry describes one loop level: a base address, a stride and a trip count. Entries are grouped into segments, and each segment holds one entry per nesting level. When the host raises a start request, the block runs the segments in order. Inside each segment it walks the nested loops, with the innermost level stepping fastest, and emits one memory address per accepted handshake.

While a kernel runs, the block acts as the local controller of the dataflow stream. Each address is offered with a valid/ready handshake. The address that closes the innermost loop carries an end-of-vector tag. Once the downstream side has taken the final address, the block raises a one-cycle done pulse, which the host uses as its end-of-kernel acknowledge. The program cannot be changed while a kernel is in flight.

Top module: `loopgen_top`

## Requirements
- R1: After reset, `addr_valid` and `done` are low. Every store entry reads as base 0, stride 0, count 0 and last 0.
- R2: While no kernel runs, a cycle with `wr_en` high writes `wr_base`, `wr_stride`, `wr_count` and `wr_last` into entry `wr_idx`. The entry for segment s and level l is at index s*LEVELS+l, and level 0 is the innermost.
- R3: A `start` seen while idle begins a kernel at segment 0 with all loop indices at zero, and `addr_valid` is high from the next cycle. A `start` seen while a kernel runs has no effect.
- R4: The offered address is the sum, over all levels of the current segment, of base plus index times stride, taken modulo 2^ADDR_W. A stride is therefore a two's-complement step that wraps.
- R5: A count field value c gives c+1 iterations of its level. Level 0 advances on every accepted address. A level advances only when every level inside it wraps, and then it wraps to zero.
- R6: Segments run in ascending order. A kernel ends after the segment whose outermost entry (level LEVELS-1) has last=1, or after segment SEGS-1 if no earlier segment is marked last.
- R7: `addr_eov` is high exactly on the addresses where the level-0 index is at its final iteration.
- R8: An address is consumed only in a cycle where `addr_valid` and `addr_ready` are both high. While `addr_ready` is low, `addr` and `addr_eov` hold their values.
- R9: `done` is high for exactly one cycle, in the cycle after the final address is accepted, and `addr_valid` is low in that cycle.
- R10: A `wr_en` seen while a kernel runs leaves the store unchanged, so the next kernel uses the earlier program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Instruction store write strobe |
| wr_idx | input | IDX_W | Entry index (segment*LEVELS+level) |
| wr_base | input | ADDR_W | Level base address |
| wr_stride | input | ADDR_W | Level stride, two's complement |
| wr_count | input | CNT_W | Trip count minus one |
| wr_last | input | 1 | Segment-final flag (used on the outermost entry) |
| start | input | 1 | Kernel start request |
| addr_ready | input | 1 | Downstream accepts the address |
| addr_valid | output | 1 | Address is offered |
| addr | output | ADDR_W | Memory address |
| addr_eov | output | 1 | End-of-vector tag |
| done | output | 1 | One-cycle end-of-kernel acknowledge |

## Verification
The first program is a single segment with unit inner stride and ready held high. It shows that the nested sums and the carry between levels are correct when nothing stalls. A second program uses two unmarked segments, a negative stride that wraps below zero and an alternating ready. This separates the segment sequencing and the end at the last segment from stall handling. A third run issues stores and a start request in the middle of a kernel under an irregular ready pattern, and then reruns the program under long stalls, which exposes any leak of those writes. A last program uses the maximum trip count with a base near the top of memory, which tests counter wrap and address wrap.

// File: rtl/loopgen_pkg.sv
package loopgen_pkg;

  // Contribution of one loop level to the address: base + index * stride.
  function automatic logic [31:0] level_term(input logic [31:0] base,
                                             input logic [31:0] stride,
                                             input logic [31:0] index);
    return base + stride * index;
  endfunction

  // Flat store position of a (segment, level) pair.
  function automatic int entry_of(input int seg, input int level, input int levels);
    return seg * levels + level;
  endfunction

endpackage

// File: rtl/loopgen_store.sv
module loopgen_store #(
  parameter int ADDR_W  = 10,
  parameter int CNT_W   = 4,
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      lock,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [ADDR_W-1:0]         wr_base,
  input  logic [ADDR_W-1:0]         wr_stride,
  input  logic [CNT_W-1:0]          wr_count,
  input  logic                      wr_last,
  output logic [ENTRIES*ADDR_W-1:0] base_all,
  output logic [ENTRIES*ADDR_W-1:0] stride_all,
  output logic [ENTRIES*CNT_W-1:0]  count_all,
  output logic [ENTRIES-1:0]        last_all
);

  logic write_ok;
  assign write_ok = wr_en & ~lock;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic hit;
    assign hit = write_ok && (wr_idx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_all[e*ADDR_W +: ADDR_W]   <= '0;
        stride_all[e*ADDR_W +: ADDR_W] <= '0;
        count_all[e*CNT_W +: CNT_W]    <= '0;
        last_all[e]                    <= 1'b0;
      end else if (hit) begin
        base_all[e*ADDR_W +: ADDR_W]   <= wr_base;
        stride_all[e*ADDR_W +: ADDR_W] <= wr_stride;
        count_all[e*CNT_W +: CNT_W]    <= wr_count;
        last_all[e]                    <= wr_last;
      end
    end
  end

  // R10: the program is frozen while a kernel is running
  assert_locked_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && wr_en) |=> ($stable(base_all) && $stable(stride_all) &&
                         $stable(count_all) && $stable(last_all)));

endmodule

// File: rtl/loopgen_nest.sv
module loopgen_nest #(
  parameter int LEVELS = 2,
  parameter int CNT_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    step,
  input  logic [LEVELS*CNT_W-1:0] limit,
  output logic [LEVELS*CNT_W-1:0] idx,
  output logic                    inner_last,
  output logic                    all_last
);

  // carry[l] is high when every level inside level l sits at its limit
  logic [LEVELS:0] carry;
  assign carry[0] = 1'b1;

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    logic at_end;
    assign at_end     = idx[l*CNT_W +: CNT_W] == limit[l*CNT_W +: CNT_W];
    assign carry[l+1] = carry[l] & at_end;
    always_ff @(posedge clk) begin
      if (!rst_n || clear)
        idx[l*CNT_W +: CNT_W] <= '0;
      else if (step && carry[l])
        idx[l*CNT_W +: CNT_W] <= at_end ? '0 : idx[l*CNT_W +: CNT_W] + 1'b1;
    end
  end

  assign inner_last = carry[1];
  assign all_last   = carry[LEVELS];

  // R7: the step that closes the innermost loop brings level 0 back to zero
  assert_inner_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && inner_last && !clear) |=> (idx[CNT_W-1:0] == '0));

  if (LEVELS > 1) begin : g_chk
    // R5: outer levels stay put until the inner level wraps
    assert_outer_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !(step && inner_last)) |=> $stable(idx[LEVELS*CNT_W-1:CNT_W]));
  end

endmodule

// File: rtl/loopgen_top.sv
module loopgen_top #(
  parameter  int ADDR_W  = 10,
  parameter  int CNT_W   = 4,
  parameter  int LEVELS  = 2,
  parameter  int SEGS    = 2,
  localparam int ENTRIES = LEVELS * SEGS,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int SEG_W   = (SEGS > 1) ? $clog2(SEGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [ADDR_W-1:0] wr_stride,
  input  logic [CNT_W-1:0]  wr_count,
  input  logic              wr_last,
  input  logic              start,
  input  logic              addr_ready,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr,
  output logic              addr_eov,
  output logic              done
);
  import loopgen_pkg::*;

  logic                      running;
  logic                      done_q;
  logic [SEG_W-1:0]          seg;
  logic [ENTRIES*ADDR_W-1:0] base_all;
  logic [ENTRIES*ADDR_W-1:0] stride_all;
  logic [ENTRIES*CNT_W-1:0]  count_all;
  logic [ENTRIES-1:0]        last_all;
  logic [LEVELS*CNT_W-1:0]   lim;
  logic [LEVELS*CNT_W-1:0]   idx;
  logic                      inner_last;
  logic                      all_last;

  // named events
  logic launch;      // idle start accepted
  logic fire;        // address handshake
  logic seg_final;   // current segment is the last one
  logic final_step;  // handshake of the kernel's final address

  assign launch     = !running && start;
  assign fire       = running && addr_ready;
  assign seg_final  = last_all[entry_of(int'(seg), LEVELS-1, LEVELS)] ||
                      (seg == SEG_W'(SEGS-1));
  assign final_step = fire && all_last && seg_final;

  loopgen_store #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .lock(running), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_base(wr_base), .wr_stride(wr_stride), .wr_count(wr_count), .wr_last(wr_last),
    .base_all(base_all), .stride_all(stride_all), .count_all(count_all),
    .last_all(last_all)
  );

  for (genvar l = 0; l < LEVELS; l++) begin : g_lim
    assign lim[l*CNT_W +: CNT_W] =
      count_all[entry_of(int'(seg), l, LEVELS)*CNT_W +: CNT_W];
  end

  loopgen_nest #(.LEVELS(LEVELS), .CNT_W(CNT_W)) u_nest (
    .clk(clk), .rst_n(rst_n), .clear(launch), .step(fire), .limit(lim),
    .idx(idx), .inner_last(inner_last), .all_last(all_last)
  );

  always_comb begin
    addr = '0;
    for (int l = 0; l < LEVELS; l++) begin
      addr = addr + ADDR_W'(level_term(
        32'(base_all[entry_of(int'(seg), l, LEVELS)*ADDR_W +: ADDR_W]),
        32'(stride_all[entry_of(int'(seg), l, LEVELS)*ADDR_W +: ADDR_W]),
        32'(idx[l*CNT_W +: CNT_W])));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      done_q  <= 1'b0;
      seg     <= '0;
    end else begin
      done_q <= final_step;
      if (launch) begin
        running <= 1'b1;
        seg     <= '0;
      end else if (final_step) begin
        running <= 1'b0;
      end else if (fire && all_last) begin
        seg <= seg + 1'b1;
      end
    end
  end

  assign addr_valid = running;
  assign addr_eov   = running && inner_last;
  assign done       = done_q;

  // R9: acknowledge lasts one cycle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: no address is offered alongside the acknowledge
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !addr_valid);
  // R8: a stalled address is held
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr) && $stable(addr_eov)));
  // R3: an idle start opens a kernel at segment 0
  assert_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_valid && start) |=> (addr_valid && seg == '0));
  // R6: segment index never runs past the store
  assert_seg_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(seg) < SEGS);

endmodule

// File: tb/loopgen_top_bench.sv
`timescale 1ns/100ps
module loopgen_top_bench;
  localparam int AW = 10;
  localparam int CW = 4;
  localparam int LV = 2;
  localparam int SG = 2;
  localparam int NE = LV * SG;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_idx = '0;
  logic [AW-1:0] wr_base = '0;
  logic [AW-1:0] wr_stride = '0;
  logic [CW-1:0] wr_count = '0;
  logic wr_last = 1'b0;
  logic start = 1'b0;
  logic addr_ready = 1'b0;
  logic addr_valid;
  logic [AW-1:0] addr;
  logic addr_eov;
  logic done;

  always #2.5 clk = ~clk;

  loopgen_top u_loopgen_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base),
    .wr_stride(wr_stride), .wr_count(wr_count), .wr_last(wr_last), .start(start),
    .addr_ready(addr_ready), .addr_valid(addr_valid), .addr(addr),
    .addr_eov(addr_eov), .done(done)
  );

  int n_checks = 0;
  int n_fails = 0;
  int cyc = 0;
  int rdy_mode = 0;

  // behavioural reference state
  int  m_base[NE];
  int  m_stride[NE];
  int  m_count[NE];
  bit  m_last[NE];
  bit  m_run = 1'b0;
  bit  m_done = 1'b0;
  int  q_addr[$];
  bit  q_eov[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  // Expected address list of a kernel (R4, R5, R6, R7)
  task automatic build_queue();
    q_addr.delete();
    q_eov.delete();
    for (int s = 0; s < SG; s++) begin
      for (int o = 0; o <= m_count[s*LV+1]; o++)
        for (int i = 0; i <= m_count[s*LV]; i++) begin
          q_addr.push_back((m_base[s*LV] + i * m_stride[s*LV] +
                            m_base[s*LV+1] + o * m_stride[s*LV+1]) % 1024);
          q_eov.push_back(i == m_count[s*LV]);
        end
      if (m_last[s*LV+1]) break;
    end
  endtask

  // ready patterns
  always @(posedge clk) begin
    #1;
    case (rdy_mode)
      0: addr_ready = 1'b1;
      1: addr_ready = cyc[0];
      2: addr_ready = ((cyc * 7) % 5) != 0;
      default: addr_ready = (cyc % 4) == 3;
    endcase
  end

  // compare every cycle, then predict the next edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      chk(1'b0, "watchdog", cyc, 50000);
      finish_run();
    end
    if (rst_n) begin
      chk(addr_valid == m_run, "R3 valid", int'(addr_valid), int'(m_run));
      if (m_run && q_addr.size() > 0) begin
        chk(int'(addr) == q_addr[0], "R4 addr", int'(addr), q_addr[0]);
        chk(addr_eov == q_eov[0], "R7 eov", int'(addr_eov), int'(q_eov[0]));
      end
      chk(done == m_done, "R9 done", int'(done), int'(m_done));
      m_done = 1'b0;
      if (m_run) begin
        // R10: stores during a run are dropped; R3: start is dropped
        if (addr_ready) begin
          void'(q_addr.pop_front());
          void'(q_eov.pop_front());
          if (q_addr.size() == 0) begin
            m_run = 1'b0;
            m_done = 1'b1;
          end
        end
      end else begin
        if (wr_en) begin // R2
          m_base[wr_idx] = int'(wr_base);
          m_stride[wr_idx] = int'(wr_stride);
          m_count[wr_idx] = int'(wr_count);
          m_last[wr_idx] = wr_last;
        end
        if (start) begin
          build_queue();
          m_run = 1'b1;
        end
      end
    end
  end

  // R2: one store write
  task automatic write_entry(input int idx, input int b, input int s, input int c,
                             input bit l);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_idx = 2'(idx); wr_base = AW'(b); wr_stride = AW'(s);
    wr_count = CW'(c); wr_last = l;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_run || m_done) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    for (int e = 0; e < NE; e++) begin
      m_base[e] = 0; m_stride[e] = 0; m_count[e] = 0; m_last[e] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(addr_valid == 1'b0, "R1 valid", int'(addr_valid), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R1: default program, two segments of one address each at 0
    pulse_start();
    wait_idle();

    // A: one marked segment, unit inner stride, ready always (R5, R6)
    write_entry(0, 5, 1, 3, 1'b0);
    write_entry(1, 100, 16, 1, 1'b1);
    rdy_mode = 0;
    pulse_start();
    wait_idle();

    // B: negative stride wrap, two unmarked segments (R4, R6, R8)
    write_entry(0, 2, 1023, 4, 1'b0);
    write_entry(1, 0, 40, 2, 1'b0);
    write_entry(2, 1000, 7, 1, 1'b0);
    write_entry(3, 20, 0, 0, 1'b0);
    rdy_mode = 1;
    pulse_start();
    wait_idle();

    // C: stores and start in mid-run are ignored (R10, R3)
    rdy_mode = 2;
    pulse_start();
    write_entry(0, 300, 5, 1, 1'b1);
    write_entry(1, 77, 3, 0, 1'b1);
    pulse_start();
    wait_idle();
    rdy_mode = 3;
    pulse_start();
    wait_idle();

    // D: full trip count, address wrap near top (R5, R7)
    write_entry(0, 1020, 3, 15, 1'b0);
    write_entry(1, 1, 512, 0, 1'b1);
    rdy_mode = 0;
    pulse_start();
    wait_idle();

    finish_run();
  end

endmodule